// File: doc/BRIEF.md
# Operand Address Mode Decoder

This block maps the 9-bit register-operand field of an instruction onto a 12-bit data-memory address. The 4096-byte data space has three regions. Special-purpose registers sit at 0x000-0x07F. Global registers sit at 0x080-0x0FF. General data memory fills 0x100-0xFFF, which is 3840 bytes. A field value other than zero names a special or global register directly. A field of all zeros selects indirect addressing instead: the address comes from a 12-bit pointer split across a high byte and a low byte.

The decoder is purely combinational and sits between instruction decode and the data-memory port. It returns the resolved address and a 2-bit mode code. It also raises a flag when an indirect access lands in the lowest 32 bytes, because that range must not be reached through the pointer. Fields with bit 8 set belong to another decoder; this one reports them as unsupported.

Top module: `opd_addr_decode`

## Requirements
- R1: With field_i[8]=0, field_i[7]=0 and field_i nonzero, addr_o equals field_i[6:0] zero-extended and mode_o is 2'b00 (special).
- R2: With field_i[8]=0 and field_i[7]=1, addr_o equals 0x080 + field_i[6:0] and mode_o is 2'b01 (global).
- R3: With field_i equal to 9'h000, mode_o is 2'b10 (indirect) and addr_o equals {ptr_hi_i[3:0], ptr_lo_i}.
- R4: ptr_hi_i[7:4] has no effect on any output.
- R5: illegal_o is 1 exactly when mode_o is indirect and addr_o is below 0x020; indirect 0x01F is flagged and 0x020 is not.
- R6: With field_i[8]=1, mode_o is 2'b11 (unsupported), addr_o is 0x000 and illegal_o is 0.
- R7: illegal_o is 0 in both direct modes, including direct addresses below 0x020.
- R8: In the direct and unsupported modes, ptr_hi_i and ptr_lo_i have no effect on any output.
- R9: Indirect mode reaches the whole general data region, up to and including 0xFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| field_i | input | 9 | Register-operand field from the instruction |
| ptr_hi_i | input | 8 | Pointer high byte; only the low nibble is used |
| ptr_lo_i | input | 8 | Pointer low byte |
| addr_o | output | 12 | Resolved data-memory address |
| mode_o | output | 2 | 00 special, 01 global, 10 indirect, 11 unsupported |
| illegal_o | output | 1 | Indirect access into 0x000-0x01F |

## Verification
Every output is a combinational function of the current field and pointer bytes, so each result is due in the same cycle as its stimulus, with no register on the way. The bench changes inputs on the falling clock edge and samples 1 ns later, well before the next rising edge. That keeps every sample clear of any edge. The boundary pair 0x01F/0x020 and the pointer extremes are checked in that same settled window.

// File: rtl/opd_pkg.sv
package opd_pkg;
  localparam int unsigned FIELD_W   = 9;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned REG_IDX_W = 7;
  localparam int unsigned PTR_B_W   = 8;
  localparam int unsigned GUARD_SZ  = 32;

  typedef enum logic [1:0] {
    MODE_SPR = 2'b00,
    MODE_GLB = 2'b01,
    MODE_IND = 2'b10,
    MODE_UNS = 2'b11
  } opd_mode_e;
endpackage

// File: rtl/opd_mode_sel.sv
module opd_mode_sel
  import opd_pkg::*;
#(
  parameter int unsigned FW = FIELD_W,
  parameter int unsigned IW = REG_IDX_W
) (
  input  logic [FW-1:0] field_i,
  output opd_mode_e     mode_o
);
  always_comb begin
    if (field_i[FW-1])          mode_o = MODE_UNS;
    else if (field_i == '0)     mode_o = MODE_IND;
    else if (field_i[IW])       mode_o = MODE_GLB;
    else                        mode_o = MODE_SPR;
  end
endmodule

// File: rtl/opd_direct_map.sv
module opd_direct_map #(
  parameter int unsigned IW = opd_pkg::REG_IDX_W,
  parameter int unsigned AW = opd_pkg::ADDR_W
) (
  input  logic [IW-1:0] idx_i,
  input  logic          glb_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] GLB_BASE = AW'(1) << IW;

  logic [AW-1:0] idx_ext;
  assign idx_ext = {{(AW-IW){1'b0}}, idx_i};
  assign addr_o  = glb_i ? (GLB_BASE | idx_ext) : idx_ext;
endmodule

// File: rtl/opd_ptr_join.sv
module opd_ptr_join #(
  parameter int unsigned AW    = opd_pkg::ADDR_W,
  parameter int unsigned BW    = opd_pkg::PTR_B_W,
  parameter int unsigned GUARD = opd_pkg::GUARD_SZ
) (
  input  logic [AW-BW-1:0] hi_i,
  input  logic [BW-1:0]    lo_i,
  output logic [AW-1:0]    addr_o,
  output logic             low_o
);
  localparam logic [AW-1:0] GUARD_LIM = AW'(GUARD);

  assign addr_o = {hi_i, lo_i};
  assign low_o  = addr_o < GUARD_LIM;
endmodule

// File: rtl/opd_addr_decode.sv
module opd_addr_decode
  import opd_pkg::*;
#(
  parameter int unsigned FW    = FIELD_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned IW    = REG_IDX_W,
  parameter int unsigned BW    = PTR_B_W,
  parameter int unsigned GUARD = GUARD_SZ
) (
  input  logic [FW-1:0] field_i,
  input  logic [BW-1:0] ptr_hi_i,
  input  logic [BW-1:0] ptr_lo_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    mode_o,
  output logic          illegal_o
);
  localparam int unsigned HI_USED = AW - BW;

  opd_mode_e     mode;
  logic [AW-1:0] dir_addr;
  logic [AW-1:0] ind_addr;
  logic          ind_low;
  logic          unused_hi;

  assign unused_hi = ^ptr_hi_i[BW-1:HI_USED];

  opd_mode_sel #(.FW(FW), .IW(IW)) i_mode_sel (
    .field_i (field_i),
    .mode_o  (mode)
  );

  opd_direct_map #(.IW(IW), .AW(AW)) i_direct_map (
    .idx_i  (field_i[IW-1:0]),
    .glb_i  (field_i[IW]),
    .addr_o (dir_addr)
  );

  opd_ptr_join #(.AW(AW), .BW(BW), .GUARD(GUARD)) i_ptr_join (
    .hi_i   (ptr_hi_i[HI_USED-1:0]),
    .lo_i   (ptr_lo_i),
    .addr_o (ind_addr),
    .low_o  (ind_low)
  );

  always_comb begin
    unique case (mode)
      MODE_SPR, MODE_GLB: addr_o = dir_addr;
      MODE_IND:           addr_o = ind_addr;
      default:            addr_o = '0;
    endcase
  end

  assign mode_o    = mode;
  assign illegal_o = (mode == MODE_IND) && ind_low;
endmodule

// File: rtl/opd_addr_decode_chk.sv
module opd_addr_decode_chk #(
  parameter int unsigned FW = 9,
  parameter int unsigned AW = 12,
  parameter int unsigned BW = 8
) (
  input logic [FW-1:0] field_i,
  input logic [BW-1:0] ptr_hi_i,
  input logic [BW-1:0] ptr_lo_i,
  input logic [AW-1:0] addr_o,
  input logic [1:0]    mode_o,
  input logic          illegal_o
);
  always_comb begin
    // R1
    if (field_i[FW-1:FW-2] == 2'b00 && field_i != '0)
      spr_map_chk: assert (mode_o == 2'b00 && addr_o == AW'(field_i[FW-3:0]));
    // R2
    if (field_i[FW-1:FW-2] == 2'b01)
      glb_map_chk: assert (mode_o == 2'b01 && addr_o == (AW'(12'h080) + AW'(field_i[FW-3:0])));
    // R3
    if (field_i == '0)
      ind_map_chk: assert (mode_o == 2'b10 && addr_o[BW-1:0] == ptr_lo_i
                           && addr_o[AW-1:BW] == ptr_hi_i[AW-BW-1:0]);
    // R5
    if (mode_o == 2'b10)
      ind_guard_chk: assert (illegal_o == (addr_o < AW'(32)));
    // R6
    if (field_i[FW-1])
      uns_mode_chk: assert (mode_o == 2'b11 && addr_o == '0 && !illegal_o);
    // R7
    if (mode_o != 2'b10)
      dir_no_err_chk: assert (!illegal_o);
  end
endmodule

bind opd_addr_decode opd_addr_decode_chk #(.FW(FW), .AW(AW), .BW(BW)) i_opd_addr_decode_chk (
  .field_i   (field_i),
  .ptr_hi_i  (ptr_hi_i),
  .ptr_lo_i  (ptr_lo_i),
  .addr_o    (addr_o),
  .mode_o    (mode_o),
  .illegal_o (illegal_o)
);

// File: tb/test_opd_addr_decode.sv
`timescale 1ns/1ps
module test_opd_addr_decode;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  field_i = '0;
  logic [7:0]  ptr_hi_i = '0;
  logic [7:0]  ptr_lo_i = '0;
  logic [11:0] addr_o;
  logic [1:0]  mode_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  opd_addr_decode i_opd_addr_decode (
    .field_i   (field_i),
    .ptr_hi_i  (ptr_hi_i),
    .ptr_lo_i  (ptr_lo_i),
    .addr_o    (addr_o),
    .mode_o    (mode_o),
    .illegal_o (illegal_o)
  );

  task automatic apply(input logic [8:0] f, input logic [7:0] h, input logic [7:0] l);
    @(negedge clk);
    field_i = f; ptr_hi_i = h; ptr_lo_i = l;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [11:0] ea,
                            input logic [1:0] em, input logic ei);
    n_chk++;
    if (addr_o !== ea || mode_o !== em || illegal_o !== ei) begin
      n_bad++;
      $display("FAIL %s: got addr=%h mode=%b ill=%b, exp addr=%h mode=%b ill=%b",
               req, addr_o, mode_o, illegal_o, ea, em, ei);
    end
  endtask

  task automatic t_reset;
    // R3 R5: quiet inputs are an indirect access to 0x000
    apply(9'h000, 8'h00, 8'h00);
    expect_out("R3/R5 idle", 12'h000, 2'b10, 1'b1);
  endtask

  task automatic t_spr;
    apply(9'h001, 8'h00, 8'h00); expect_out("R1 spr 1",  12'h001, 2'b00, 1'b0);
    apply(9'h012, 8'hAA, 8'h55); expect_out("R1 spr 12", 12'h012, 2'b00, 1'b0);
    apply(9'h07F, 8'h00, 8'h00); expect_out("R1 spr 7F", 12'h07F, 2'b00, 1'b0);
  endtask

  task automatic t_glb;
    apply(9'h080, 8'h00, 8'h00); expect_out("R2 glb 0",  12'h080, 2'b01, 1'b0);
    apply(9'h0C3, 8'h00, 8'h00); expect_out("R2 glb 43", 12'h0C3, 2'b01, 1'b0);
    apply(9'h0FF, 8'h00, 8'h00); expect_out("R2 glb 7F", 12'h0FF, 2'b01, 1'b0);
  endtask

  task automatic t_ind;
    apply(9'h000, 8'h03, 8'h47); expect_out("R3 ind 347", 12'h347, 2'b10, 1'b0);
    apply(9'h000, 8'h01, 8'h00); expect_out("R9 ind 100", 12'h100, 2'b10, 1'b0);
    apply(9'h000, 8'h0F, 8'hFF); expect_out("R9 ind FFF", 12'hFFF, 2'b10, 1'b0);
    apply(9'h000, 8'h00, 8'h80); expect_out("R3 ind 080", 12'h080, 2'b10, 1'b0);
  endtask

  task automatic t_hi_nibble;
    for (int k = 0; k < 16; k++) begin
      apply(9'h000, {k[3:0], 4'hA}, 8'h5C);
      expect_out("R4 hi nibble", 12'hA5C, 2'b10, 1'b0);
    end
    apply(9'h000, 8'hF0, 8'h10); expect_out("R4 hi ign low", 12'h010, 2'b10, 1'b1);
  endtask

  task automatic t_guard;
    apply(9'h000, 8'h00, 8'h1F); expect_out("R5 ind 01F", 12'h01F, 2'b10, 1'b1);
    apply(9'h000, 8'h00, 8'h20); expect_out("R5 ind 020", 12'h020, 2'b10, 1'b0);
    apply(9'h000, 8'h10, 8'h05); expect_out("R5 ind 005", 12'h005, 2'b10, 1'b1);
  endtask

  task automatic t_direct_low;
    apply(9'h01F, 8'h00, 8'h00); expect_out("R7 spr 1F", 12'h01F, 2'b00, 1'b0);
    apply(9'h005, 8'h00, 8'h05); expect_out("R7 spr 05", 12'h005, 2'b00, 1'b0);
  endtask

  task automatic t_uns;
    apply(9'h100, 8'h00, 8'h00); expect_out("R6 uns 100", 12'h000, 2'b11, 1'b0);
    apply(9'h1FF, 8'h0F, 8'h10); expect_out("R6 uns 1FF", 12'h000, 2'b11, 1'b0);
  endtask

  task automatic t_ptr_ignored;
    for (int k = 0; k < 8; k++) begin
      apply(9'h023, 8'(k * 37), 8'(k * 91));
      expect_out("R8 spr ptr", 12'h023, 2'b00, 1'b0);
      apply(9'h0A3, 8'(k * 53), 8'(k * 29));
      expect_out("R8 glb ptr", 12'h0A3, 2'b01, 1'b0);
      apply(9'h155, 8'(k * 11), 8'(k * 7));
      expect_out("R8 uns ptr", 12'h000, 2'b11, 1'b0);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got cycle=%0d, exp below 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_spr();
    t_glb();
    t_ind();
    t_hi_nibble();
    t_guard();
    t_direct_low();
    t_uns();
    t_ptr_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule